// File: doc/BRIEF.md
# Two-Stage Parallel Register Loader

This block moves configuration and tuning words from a host bus into a set of destination registers in two steps. Each host write strobe shifts a byte or a half-word into a 32-bit staging word. Until the host issues a separate transfer strobe with a 4-bit destination code, every destination register keeps its value. The transfer strobe then copies the staging word into the selected destination.

There are three kinds of destination:
- a configuration register that sets the bus width, the sleep flag, the amplitude-control enable and the synchronizer bypass;
- two 32-bit frequency registers;
- two 16-bit phase registers.

The bus width is changed through the same path as any other setting: the host stages a configuration word and then transfers it. A 32-bit value is written most significant part first. A transfer does not consume the staging word, so the same value can be sent to several destinations.

Top module: `par_load_if`

## Requirements
- R1: Reset (synchronous, active high) selects 8-bit bus mode, clears sleep and amplitude control, enables the synchronizer (`sync_en_o`=1), and clears the staging word and all frequency and phase registers to zero.
- R2: In 8-bit mode each write shifts the staging word left by 8. `wr_data[7:0]` enters bits 7:0 and `wr_data[15:8]` is ignored, so four writes build a word with the first byte in bits 31:24.
- R3: In 16-bit mode each write shifts the staging word left by 16 and `wr_data` enters bits 15:0, so writing the upper half-word and then the lower half-word builds the 32-bit value.
- R4: A write changes no destination register. Destinations change only on a transfer strobe.
- R5: Transfer code 0000 loads the configuration register from staging bits 3:0: bit 0 = 16-bit bus, bit 1 = sleep, bit 2 = amplitude-control enable, bit 3 = synchronizer bypass (`sync_en_o` is its inverse).
- R6: Code 1000 loads frequency register 0 and code 1001 loads frequency register 1, each with the full 32-bit staging word.
- R7: Code 1010 loads phase register 0 and code 1011 loads phase register 1, each with staging bits 15:0.
- R8: Any other transfer code leaves the configuration register and every frequency and phase register unchanged.
- R9: A new bus width applies from the first write after the configuration transfer. A transfer leaves the staging word intact, so repeating a transfer sends the same value again.
- R10: When a write and a transfer share a cycle, the transfer copies the staging word as it was before that write, and the write still shifts in.
- R11: Strobes are sampled on the rising clock edge. Each cycle a strobe is high counts as one separate operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one shift per cycle high |
| wr_data | input | 16 | Host write data (bits 7:0 used in 8-bit mode) |
| ld_en | input | 1 | Transfer strobe |
| ld_code | input | 4 | Destination code for the transfer |
| bus_wide_o | output | 1 | 1 = 16-bit bus mode |
| sleep_o | output | 1 | Sleep flag |
| amp_en_o | output | 1 | Amplitude-control enable |
| sync_en_o | output | 1 | Synchronizer enabled |
| freq_o | output | 2x32 | Frequency registers, index 0 and 1 |
| phase_o | output | 2x16 | Phase registers, index 0 and 1 |

## Verification
The main path is tried with full four-byte words in 8-bit mode, where the upper data bytes carry junk that must not appear, and with two half-word writes in 16-bit mode. Each of these targets a different destination code, so a mix-up in shift amount, byte order or decode shows up as a wrong value in one particular register. The bench switches bus width between vectors to separate the cycle on which a width change takes effect. Unused codes, repeated transfers, a write coinciding with a transfer, and a strobe held for two cycles distinguish staging-word preservation and per-cycle sampling from other plausible behaviours.

// File: rtl/par_load_pkg.sv
package par_load_pkg;

    localparam int WORD_W    = 32;
    localparam int WIDE_W    = 16;
    localparam int NARROW_W  = 8;
    localparam int PHASE_W   = 16;
    localparam int CODE_W    = 4;
    localparam int NUM_FREQ  = 2;
    localparam int NUM_PHASE = 2;

    // configuration word layout, taken from the low staging bits
    typedef struct packed {
        logic sync_off;
        logic amp_en;
        logic sleep;
        logic wide;
    } cfg_t;

    localparam int   CFG_W     = $bits(cfg_t);
    localparam cfg_t CFG_RESET = '0;

    typedef enum logic [CODE_W-1:0] {
        XFER_CFG        = 4'b0000,
        XFER_FREQ_BASE  = 4'b1000,
        XFER_PHASE_BASE = 4'b1010
    } xfer_code_e;

    // true when code addresses entry idx of a group starting at base
    function automatic logic code_hits(logic [CODE_W-1:0] code,
                                       xfer_code_e base, int idx);
        return code == CODE_W'(int'(base) + idx);
    endfunction

endpackage

// File: rtl/par_load_asm.sv
module par_load_asm
    import par_load_pkg::*;
#(
    parameter int WORD_W_P   = WORD_W,
    parameter int WIDE_W_P   = WIDE_W,
    parameter int NARROW_W_P = NARROW_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [WIDE_W_P-1:0]   wr_data,
    input  logic                  wide,
    output logic [WORD_W_P-1:0]   asm_q
);
    localparam int KEEP_WIDE   = WORD_W_P - WIDE_W_P;
    localparam int KEEP_NARROW = WORD_W_P - NARROW_W_P;

    logic [WORD_W_P-1:0] asm_d;

    always_comb begin
        asm_d = asm_q;
        if (wr_en) begin
            if (wide)
                asm_d = {asm_q[KEEP_WIDE-1:0], wr_data};
            else
                asm_d = {asm_q[KEEP_NARROW-1:0], wr_data[NARROW_W_P-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) asm_q <= '0;
        else     asm_q <= asm_d;
    end

    // R2
    narrow_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wide) |=> (asm_q[NARROW_W_P-1:0] == $past(wr_data[NARROW_W_P-1:0])
                              && asm_q[WORD_W_P-1:NARROW_W_P] == $past(asm_q[KEEP_NARROW-1:0])));

    // R3
    wide_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wide) |=> (asm_q[WIDE_W_P-1:0] == $past(wr_data)
                             && asm_q[WORD_W_P-1:WIDE_W_P] == $past(asm_q[KEEP_WIDE-1:0])));

    // R9
    staging_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(asm_q));

endmodule

// File: rtl/par_load_decode.sv
module par_load_decode
    import par_load_pkg::*;
#(
    parameter int NUM_FREQ_P  = NUM_FREQ,
    parameter int NUM_PHASE_P = NUM_PHASE
) (
    input  logic                   ld_en,
    input  logic [CODE_W-1:0]      ld_code,
    output logic                   sel_cfg,
    output logic [NUM_FREQ_P-1:0]  sel_freq,
    output logic [NUM_PHASE_P-1:0] sel_phase,
    output logic                   hit
);
    assign sel_cfg = ld_en && (ld_code == XFER_CFG);

    for (genvar i = 0; i < NUM_FREQ_P; i++) begin : g_freq
        assign sel_freq[i] = ld_en && code_hits(ld_code, XFER_FREQ_BASE, i);
    end

    for (genvar j = 0; j < NUM_PHASE_P; j++) begin : g_phase
        assign sel_phase[j] = ld_en && code_hits(ld_code, XFER_PHASE_BASE, j);
    end

    assign hit = sel_cfg || (|sel_freq) || (|sel_phase);

endmodule

// File: rtl/par_load_bank.sv
module par_load_bank #(
    parameter int W = 32,
    parameter int N = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        sel,
    input  logic [W-1:0]        din,
    output logic [N-1:0][W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (sel[i]) q[i] <= din;
            end
        end
    end

    // R4
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(|sel) |=> $stable(q));

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R6
        load_take_chk: assert property (@(posedge clk) disable iff (rst)
            sel[i] |=> (q[i] == $past(din)));
    end

endmodule

// File: rtl/par_load_if.sv
module par_load_if
    import par_load_pkg::*;
#(
    parameter int NUM_FREQ_P  = NUM_FREQ,
    parameter int NUM_PHASE_P = NUM_PHASE
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr_en,
    input  logic [WIDE_W-1:0]                   wr_data,
    input  logic                                ld_en,
    input  logic [CODE_W-1:0]                   ld_code,
    output logic                                bus_wide_o,
    output logic                                sleep_o,
    output logic                                amp_en_o,
    output logic                                sync_en_o,
    output logic [NUM_FREQ_P-1:0][WORD_W-1:0]   freq_o,
    output logic [NUM_PHASE_P-1:0][PHASE_W-1:0] phase_o
);
    logic [WORD_W-1:0]      asm_q;
    cfg_t                   cfg_q;
    logic                   sel_cfg;
    logic [NUM_FREQ_P-1:0]  sel_freq;
    logic [NUM_PHASE_P-1:0] sel_phase;
    logic                   hit;

    par_load_asm #(
        .WORD_W_P(WORD_W), .WIDE_W_P(WIDE_W), .NARROW_W_P(NARROW_W)
    ) u_asm (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .wide(cfg_q.wide), .asm_q(asm_q)
    );

    par_load_decode #(
        .NUM_FREQ_P(NUM_FREQ_P), .NUM_PHASE_P(NUM_PHASE_P)
    ) u_dec (
        .ld_en(ld_en), .ld_code(ld_code), .sel_cfg(sel_cfg),
        .sel_freq(sel_freq), .sel_phase(sel_phase), .hit(hit)
    );

    par_load_bank #(.W(WORD_W), .N(NUM_FREQ_P)) u_freq (
        .clk(clk), .rst(rst), .sel(sel_freq), .din(asm_q), .q(freq_o)
    );

    par_load_bank #(.W(PHASE_W), .N(NUM_PHASE_P)) u_phase (
        .clk(clk), .rst(rst), .sel(sel_phase), .din(asm_q[PHASE_W-1:0]), .q(phase_o)
    );

    always_ff @(posedge clk) begin
        if (rst)          cfg_q <= CFG_RESET;
        else if (sel_cfg) cfg_q <= cfg_t'(asm_q[CFG_W-1:0]);
    end

    assign bus_wide_o = cfg_q.wide;
    assign sleep_o    = cfg_q.sleep;
    assign amp_en_o   = cfg_q.amp_en;
    assign sync_en_o  = !cfg_q.sync_off;

    // R1
    cfg_reset_chk: assert property (@(posedge clk)
        rst |=> (!bus_wide_o && !sleep_o && !amp_en_o && sync_en_o));

    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sel_cfg |=> $stable(cfg_q));

    // R8
    unused_code_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_en && !hit) |=> ($stable(cfg_q) && $stable(freq_o) && $stable(phase_o)));

    // R4
    write_only_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ld_en) |=> ($stable(cfg_q) && $stable(freq_o) && $stable(phase_o)));

endmodule

// File: tb/par_load_if_test.sv
module par_load_if_test;

    typedef struct packed {
        logic             wide;
        logic [2:0]       n;
        logic [3:0][15:0] d;
        logic [3:0]       code;
        logic [31:0]      exp;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 3'd4, {16'hAB12, 16'hCD34, 16'hEF56, 16'h0178}, 4'h8, 32'h12345678},
        '{1'b1, 3'd2, {16'h051E, 16'hB852, 16'h0000, 16'h0000}, 4'h9, 32'h051EB852},
        '{1'b0, 3'd4, {16'h0011, 16'h0022, 16'h009A, 16'h00BC}, 4'hA, 32'h00009ABC},
        '{1'b1, 3'd2, {16'hFFFF, 16'h0123, 16'h0000, 16'h0000}, 4'hB, 32'h00000123},
        '{1'b1, 3'd2, {16'hA5A5, 16'h5A5A, 16'h0000, 16'h0000}, 4'h8, 32'hA5A55A5A}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [15:0]      wr_data = '0;
    logic             ld_en = 1'b0;
    logic [3:0]       ld_code = '0;
    logic             bus_wide_o, sleep_o, amp_en_o, sync_en_o;
    logic [1:0][31:0] freq_o;
    logic [1:0][15:0] phase_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0] m_freq [2];
    logic [15:0] m_phase [2];

    par_load_if uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .ld_en(ld_en), .ld_code(ld_code), .bus_wide_o(bus_wide_o),
        .sleep_o(sleep_o), .amp_en_o(amp_en_o), .sync_en_o(sync_en_o),
        .freq_o(freq_o), .phase_o(phase_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: act %0d cycles exp completion", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act %h exp %h", req, act, exp);
        end
    endtask

    task automatic do_write(logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_load(logic [3:0] c);
        @(negedge clk); ld_en = 1'b1; ld_code = c;
        @(negedge clk); ld_en = 1'b0;
    endtask

    function automatic logic [31:0] pick(logic [3:0] c);
        case (c)
            4'h8:    return freq_o[0];
            4'h9:    return freq_o[1];
            4'hA:    return {16'h0, phase_o[0]};
            default: return {16'h0, phase_o[1]};
        endcase
    endfunction

    task automatic check_all(string req);
        check(req, freq_o[0], m_freq[0]);
        check(req, freq_o[1], m_freq[1]);
        check(req, {16'h0, phase_o[0]}, {16'h0, m_phase[0]});
        check(req, {16'h0, phase_o[1]}, {16'h0, m_phase[1]});
    endtask

    task automatic check_cfg(string req, logic w, logic s, logic a, logic y);
        check(req, {28'h0, bus_wide_o, sleep_o, amp_en_o, sync_en_o}, {28'h0, w, s, a, y});
    endtask

    initial begin
        m_freq[0] = '0; m_freq[1] = '0; m_phase[0] = '0; m_phase[1] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 defaults after reset
        check_cfg("R1 cfg", 1'b0, 1'b0, 1'b0, 1'b1);
        check_all("R1 regs");

        // table walk: set width, fill staging word, transfer
        for (int v = 0; v < NV; v++) begin
            do_write({15'h0, VEC[v].wide});
            do_load(4'h0);
            check_cfg("R5 width", VEC[v].wide, 1'b0, 1'b0, 1'b1);
            for (int k = 0; k < int'(VEC[v].n); k++) do_write(VEC[v].d[3-k]);
            check_all("R4 write only");
            do_load(VEC[v].code);
            // R2 R3 R6 R7 R9: value built in the new width lands in its destination
            check(VEC[v].wide ? "R3 R9 value" : "R2 R9 value", pick(VEC[v].code), VEC[v].exp);
            case (VEC[v].code)
                4'h8: m_freq[0] = VEC[v].exp;
                4'h9: m_freq[1] = VEC[v].exp;
                4'hA: m_phase[0] = VEC[v].exp[15:0];
                default: m_phase[1] = VEC[v].exp[15:0];
            endcase
            check_all("R6 R7 others");
        end

        // R8 unused codes change nothing
        do_load(4'h5); do_load(4'hF); do_load(4'h1); do_load(4'hC);
        check_all("R8 regs");
        check_cfg("R8 cfg", 1'b1, 1'b0, 1'b0, 1'b1);

        // R9 transfer keeps the staging word
        do_load(4'h9);
        m_freq[1] = 32'hA5A55A5A;
        check("R9 repeat", freq_o[1], 32'hA5A55A5A);

        // R10 write and transfer in one cycle
        @(negedge clk); wr_en = 1'b1; wr_data = 16'h1111; ld_en = 1'b1; ld_code = 4'hA;
        @(negedge clk); wr_en = 1'b0; ld_en = 1'b0;
        check("R10 old word", {16'h0, phase_o[0]}, 32'h00005A5A);
        do_load(4'hB);
        check("R10 write kept", {16'h0, phase_o[1]}, 32'h00001111);
        do_load(4'h9);
        check("R10 shifted", freq_o[1], 32'h5A5A1111);

        // R11 strobe held two cycles gives two writes
        @(negedge clk); wr_en = 1'b1; wr_data = 16'h2222;
        @(negedge clk); wr_data = 16'h3333;
        @(negedge clk); wr_en = 1'b0;
        do_load(4'h8);
        check("R11 held", freq_o[0], 32'h22223333);

        // R5 all configuration fields
        do_write(16'h000E);
        do_load(4'h0);
        check_cfg("R5 fields", 1'b0, 1'b1, 1'b1, 1'b0);
        // R2 narrow write, upper byte ignored
        do_write(16'hF001);
        do_load(4'h0);
        check_cfg("R2 R5 narrow", 1'b1, 1'b0, 1'b0, 1'b1);

        // R1 reset during operation
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        m_freq[0] = '0; m_freq[1] = '0; m_phase[0] = '0; m_phase[1] = '0;
        check_cfg("R1 cfg again", 1'b0, 1'b0, 1'b0, 1'b1);
        check_all("R1 regs again");
        do_write(16'h0000);
        do_load(4'h8);
        check("R1 staging cleared", freq_o[0], 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule